// File: doc/BRIEF.md
# Spindle Speed Supervisor

This block watches the sector-slot pulses of a spinning disk platter. It decides when the spindle has reached a steady nominal speed, and it raises a sticky underspeed fault if the speed later falls below 70 % of nominal. A cycle counter measures the gap between accepted sector pulses. A run counter holds the speed accumulator in a squelched state until the gap measurement has settled. The accumulator then counts good periods up to a qualification threshold. Reaching that threshold releases the reset on the underspeed latch.

At the nominal 1500 RPM there are eight sector slots per turn, so the nominal sector period is 5 ms. A ninth, index slot sits just after one sector slot. Its pulse arrives far too soon after the previous sector pulse to be a sector, so the block ignores it. While the drive is still spinning up, slow periods cannot latch a fault. After qualification, the fault is cleared only by dropping motor-on. The qualification itself is withdrawn only after the platter has almost stopped, which is treated as no accepted pulse for fifty nominal periods, about 30 RPM.

Top module: `spd_supervisor`

## Requirements
- R1: After reset, `speed_ok` and `underspeed_fault` are 0 and `squelch` is 1.
- R2: A gap of g clock cycles between accepted sector rising edges is in limit when g <= SLOW_LIMIT. SLOW_LIMIT is NOM_PERIOD*10/7, rounded down, which is 142 for NOM_PERIOD = 100. A gap longer than this is underspeed, and underspeed is flagged as soon as the elapsed count passes SLOW_LIMIT.
- R3: A rising edge that arrives fewer than NOM_PERIOD/4 cycles after the last accepted sector edge is an index pulse. It neither ends nor restarts the period being measured.
- R4: `squelch` is 0 only while motor-on is 1 and the last SETTLE_PERIODS completed periods were all in limit. Any underspeed, or motor-on at 0, sets `squelch` back to 1 and restarts the run.
- R5: The drive becomes qualified after QUAL_PERIODS in-limit periods have been counted while `squelch` is 0. These periods come after the one that released squelch.
- R6: Before qualification, underspeed never sets `underspeed_fault`.
- R7: After qualification, underspeed while motor-on is 1 sets `underspeed_fault`. The fault stays set through later in-limit periods.
- R8: While motor-on is 0, `underspeed_fault` is 0.
- R9: Qualification is withdrawn when no sector edge has been accepted for NOM_PERIOD*50 cycles. After that, underspeed does not set the fault until the drive qualifies again.
- R10: `speed_ok` is 1 only when the drive is qualified, motor-on is 1 and no fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| motor_on | input | 1 | Spindle motor enable level |
| sector_in | input | 1 | Raw slot pulse from the sector sensor (asynchronous) |
| speed_ok | output | 1 | Drive qualified at speed with no fault |
| underspeed_fault | output | 1 | Sticky underspeed latch |
| squelch | output | 1 | Debug: accumulator held off |

## Verification
The hardest situation to reach is the exact boundary between an in-limit gap and an underspeed gap, once the squelch has released but before the drive has qualified. The bench resets the block for each gap length from 138 to 146 cycles. It lets three nominal periods release squelch and then times the next edge at exactly that gap. Where a check waits after an edge, the wait is taken out of the next gap. The fault-clearing path past a near stop is reached by letting the pulse stream go silent for more than fifty nominal periods with motor-on dropped.

// File: rtl/spd_pkg.sv
package spd_pkg;

  // One completed sector period, reported for a single cycle.
  typedef struct packed {
    logic valid;     // a sector-to-sector gap has just been measured
    logic in_limit;  // gap was not longer than the underspeed limit
  } gap_evt_t;

endpackage

// File: rtl/spd_edge_sync.sv
module spd_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int TOTAL = SYNC_STAGES + 1;

  logic [TOTAL-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < TOTAL; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign rise = chain[TOTAL-2] & ~chain[TOTAL-1];
endmodule

// File: rtl/spd_gap_meter.sv
module spd_gap_meter
  import spd_pkg::*;
#(
  parameter int NOM_PERIOD = 250000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rise,
  output gap_evt_t evt,
  output logic     slow,
  output logic     stopped
);
  localparam int SLOW_LIMIT = (NOM_PERIOD * 10) / 7;
  localparam int MIN_GAP    = NOM_PERIOD / 4;
  localparam int STOP_LIMIT = NOM_PERIOD * 50;
  localparam int CNT_W      = $clog2(STOP_LIMIT + 1);

  logic [CNT_W-1:0] cnt;
  logic             have_prev;
  logic             accept;
  logic             first;

  assign first  = rise & ~have_prev;
  assign accept = rise & have_prev & (cnt >= CNT_W'(MIN_GAP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      have_prev <= 1'b0;
      slow      <= 1'b0;
      stopped   <= 1'b0;
      evt       <= '0;
    end else begin
      evt <= '0;
      if (first) begin
        have_prev <= 1'b1;
        cnt       <= CNT_W'(1);
        stopped   <= 1'b0;
      end else if (accept) begin
        evt.valid    <= 1'b1;
        evt.in_limit <= (cnt <= CNT_W'(SLOW_LIMIT));
        slow         <= (cnt > CNT_W'(SLOW_LIMIT));
        cnt          <= CNT_W'(1);
        stopped      <= 1'b0;
      end else begin
        // no edge, or an index edge that is too early: keep timing
        if (cnt < CNT_W'(STOP_LIMIT))      cnt     <= cnt + 1'b1;
        if (cnt >= CNT_W'(SLOW_LIMIT))     slow    <= 1'b1;
        if (cnt >= CNT_W'(STOP_LIMIT - 1)) stopped <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spd_settle.sv
module spd_settle
  import spd_pkg::*;
#(
  parameter int SETTLE_PERIODS = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  motor_on,
  input  gap_evt_t                              evt,
  input  logic                                  slow,
  output logic [$clog2(SETTLE_PERIODS+1)-1:0]   run_cnt,
  output logic                                  squelch
);
  localparam int RUN_W = $clog2(SETTLE_PERIODS + 1);

  logic steady;
  logic broken;

  assign broken = ~motor_on | slow | (evt.valid & ~evt.in_limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                                              run_cnt <= '0;
    else if (broken)                                         run_cnt <= '0;
    else if (evt.valid && run_cnt < RUN_W'(SETTLE_PERIODS))  run_cnt <= run_cnt + 1'b1;
  end

  assign steady  = (run_cnt == RUN_W'(SETTLE_PERIODS));
  assign squelch = ~(motor_on & steady);
endmodule

// File: rtl/spd_qualify.sv
module spd_qualify
  import spd_pkg::*;
#(
  parameter int QUAL_PERIODS = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     motor_on,
  input  logic     squelch,
  input  gap_evt_t evt,
  input  logic     slow,
  input  logic     stopped,
  output logic     qualified,
  output logic     fault
);
  localparam int ACC_W = $clog2(QUAL_PERIODS + 1);

  logic [ACC_W-1:0] acc;
  logic             reached;

  assign reached = (acc == ACC_W'(QUAL_PERIODS));

  // speed accumulator, held at zero while squelched
  always_ff @(posedge clk) begin
    if (!rst_n)                                       acc <= '0;
    else if (squelch)                                 acc <= '0;
    else if (evt.valid && evt.in_limit && !reached)   acc <= acc + 1'b1;
  end

  // latch reset: active until qualified, active again after near stop
  always_ff @(posedge clk) begin
    if (!rst_n)       qualified <= 1'b0;
    else if (stopped) qualified <= 1'b0;
    else if (reached) qualified <= 1'b1;
  end

  // sticky underspeed latch
  always_ff @(posedge clk) begin
    if (!rst_n)                 fault <= 1'b0;
    else if (!motor_on)         fault <= 1'b0;
    else if (qualified && slow) fault <= 1'b1;
  end
endmodule

// File: rtl/spd_supervisor.sv
module spd_supervisor
  import spd_pkg::*;
#(
  parameter int NOM_PERIOD     = 250000,
  parameter int SETTLE_PERIODS = 8,
  parameter int QUAL_PERIODS   = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic motor_on,
  input  logic sector_in,
  output logic speed_ok,
  output logic underspeed_fault,
  output logic squelch
);
  localparam int RUN_W = $clog2(SETTLE_PERIODS + 1);

  logic             rise;
  gap_evt_t         evt;
  logic             slow;
  logic             stopped;
  logic [RUN_W-1:0] run_cnt;
  logic             qualified;

  spd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sector_in), .rise(rise)
  );

  spd_gap_meter #(.NOM_PERIOD(NOM_PERIOD)) u_meter (
    .clk(clk), .rst_n(rst_n), .rise(rise),
    .evt(evt), .slow(slow), .stopped(stopped)
  );

  spd_settle #(.SETTLE_PERIODS(SETTLE_PERIODS)) u_settle (
    .clk(clk), .rst_n(rst_n), .motor_on(motor_on), .evt(evt),
    .slow(slow), .run_cnt(run_cnt), .squelch(squelch)
  );

  spd_qualify #(.QUAL_PERIODS(QUAL_PERIODS)) u_qual (
    .clk(clk), .rst_n(rst_n), .motor_on(motor_on), .squelch(squelch),
    .evt(evt), .slow(slow), .stopped(stopped),
    .qualified(qualified), .fault(underspeed_fault)
  );

  assign speed_ok = qualified & motor_on & ~underspeed_fault;
endmodule

// File: rtl/spd_supervisor_chk.sv
module spd_supervisor_chk #(
  parameter int SETTLE_PERIODS = 8,
  parameter int RUN_W          = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             motor_on,
  input logic             speed_ok,
  input logic             underspeed_fault,
  input logic             squelch,
  input logic             qualified,
  input logic             stopped,
  input logic [RUN_W-1:0] run_cnt
);
  p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !motor_on |=> !underspeed_fault);

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (underspeed_fault && motor_on) |=> underspeed_fault);

  p_fault_needs_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underspeed_fault) |-> $past(qualified));

  p_qual_needs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified) |-> $past(!squelch, 2));

  p_stop_drops_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> !speed_ok);

  // R4: the settle run never counts past its target
  always_ff @(posedge clk) begin
    if (rst_n) begin
      p_run_bound_r4: assert (run_cnt <= RUN_W'(SETTLE_PERIODS));
    end
  end
endmodule

bind spd_supervisor spd_supervisor_chk #(
  .SETTLE_PERIODS(SETTLE_PERIODS),
  .RUN_W($clog2(SETTLE_PERIODS + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .motor_on(motor_on), .speed_ok(speed_ok),
  .underspeed_fault(underspeed_fault), .squelch(squelch),
  .qualified(qualified), .stopped(stopped), .run_cnt(run_cnt)
);

// File: tb/spd_supervisor_tb.sv
module spd_supervisor_tb;
  localparam int NOM    = 100;
  localparam int SLOWL  = (NOM * 10) / 7;   // 142
  localparam int STOPL  = NOM * 50;         // 5000
  localparam int SETTLE = 3;
  localparam int QUAL   = 4;
  localparam int WAITC  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic motor_on = 1'b0;
  logic sector_in = 1'b0;
  logic speed_ok, underspeed_fault, squelch;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  spd_supervisor #(
    .NOM_PERIOD(NOM), .SETTLE_PERIODS(SETTLE), .QUAL_PERIODS(QUAL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .motor_on(motor_on), .sector_in(sector_in),
    .speed_ok(speed_ok), .underspeed_fault(underspeed_fault), .squelch(squelch)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // sector rising edges spaced exactly g cycles apart
  task automatic gap(input int g);
    repeat (g - 1) @(negedge clk);
    sector_in = 1'b1;
    @(negedge clk);
    sector_in = 1'b0;
  endtask

  // same, with an index pulse 10 cycles into the period
  task automatic gap_idx(input int g);
    repeat (9) @(negedge clk);
    sector_in = 1'b1;
    @(negedge clk);
    sector_in = 1'b0;
    repeat (g - 11) @(negedge clk);
    sector_in = 1'b1;
    @(negedge clk);
    sector_in = 1'b0;
  endtask

  task automatic settle_wait;
    repeat (WAITC) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    motor_on = 1'b0;
    sector_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 speed_ok", speed_ok, 1'b0);
    chk("R1 fault", underspeed_fault, 1'b0);
    chk("R1 squelch", squelch, 1'b1);

    // R2/R4 boundary sweep before qualification
    for (int g = SLOWL - 4; g <= SLOWL + 4; g++) begin
      do_reset();
      motor_on = 1'b1;
      repeat (SETTLE + 1) gap(NOM);
      settle_wait();
      chk("R4 squelch released", squelch, 1'b0);
      gap(g - WAITC);
      settle_wait();
      chk("R2 R4 squelch vs gap", squelch, (g > SLOWL));
      chk("R6 no fault before qual", underspeed_fault, 1'b0);
    end

    // main spin-up
    do_reset();
    motor_on = 1'b1;
    gap(400); gap(300); gap(200); gap(160);
    settle_wait();
    chk("R4 squelch while slow", squelch, 1'b1);
    chk("R6 no fault during spin-up", underspeed_fault, 1'b0);
    chk("R10 not ok during spin-up", speed_ok, 1'b0);
    gap(130 - WAITC); gap(120);
    settle_wait();
    chk("R4 squelch after two good", squelch, 1'b1);
    gap(110 - WAITC);
    settle_wait();
    chk("R4 squelch after three good", squelch, 1'b0);
    // R3/R5: index pulses must not disturb the count
    gap_idx(NOM - WAITC); gap_idx(NOM); gap_idx(NOM);
    settle_wait();
    chk("R3 index ignored, squelch", squelch, 1'b0);
    chk("R5 not yet qualified", speed_ok, 1'b0);
    gap_idx(NOM - WAITC);
    settle_wait();
    chk("R5 R10 qualified", speed_ok, 1'b1);
    gap(SLOWL - WAITC);
    settle_wait();
    chk("R2 limit gap no fault", underspeed_fault, 1'b0);
    gap(SLOWL + 1 - WAITC);
    settle_wait();
    chk("R7 fault on underspeed", underspeed_fault, 1'b1);
    chk("R10 not ok with fault", speed_ok, 1'b0);
    gap(NOM); gap(NOM); gap(NOM);
    settle_wait();
    chk("R7 fault sticky", underspeed_fault, 1'b1);
    motor_on = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 fault cleared", underspeed_fault, 1'b0);
    chk("R10 not ok motor off", speed_ok, 1'b0);
    gap(200); gap(200);
    settle_wait();
    chk("R8 fault held clear", underspeed_fault, 1'b0);
    repeat (STOPL + 200) @(negedge clk);
    motor_on = 1'b1;
    gap(300); gap(300); gap(300);
    settle_wait();
    chk("R9 no fault after stop", underspeed_fault, 1'b0);
    chk("R9 not qualified after stop", speed_ok, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule